// File: doc/BRIEF.md
# LCD panel timing generator

This block produces the line and frame timing for an active-matrix display panel. Four configuration words set the active area, the horizontal and vertical porches, the sync widths, per-signal polarity, the launch edge of the syncs and a sync alignment mode. The block runs from a single pixel clock. It drives horizontal sync, vertical sync, data-enable and a forwarded pixel clock to the panel. It also gives its current position and a one-clock-early pixel request to an upstream pixel source.

Each line is a horizontal sync pulse, then a back porch, then the active pixels, then a front porch. Each frame follows the same order in lines. The configuration is latched into shadow registers once per frame. The first latch happens on the first clock after reset. Software can therefore rewrite the words at any time without corrupting the frame in progress.

Top module: `lcd_timing_gen`

## Requirements
- R1: Horizontal periods are taken from the horizontal word. Sync width is bits 7:0, front porch is bits 19:8 and back porch is bits 31:20. The active width is bits 13:0 of the size word. Each period lasts its field value plus one clock. Within a line the order is sync, back porch, active, front porch.
- R2: Vertical sync width is bits 7:0 of the vertical word and lasts its value plus one lines. The vertical porches are bits 31:20 (back) and bits 19:8 (front) and last exactly their value in lines, so a zero gives no porch lines. The active height is bits 29:16 of the size word plus one. Within a frame the order is sync, back porch, active, front porch.
- R3: Data-enable is active only when the pixel lies in both the horizontal and the vertical active regions.
- R4: `pixReq` is active high and is asserted exactly one clock before each clock in which data-enable is active.
- R5: Polarity word bit 13 inverts HSYNC, bit 12 inverts VSYNC and bit 15 inverts data-enable. With its bit clear, a signal is active high.
- R6: Polarity bit 14 inverts `pclkOut`. With bit 14 clear, data-enable changes on the rising edge of `pclkOut`. With bit 14 set, it changes on the falling edge.
- R7: With polarity bit 17 clear, both syncs launch on the falling edge of `clkIn`, which is the edge opposite the data. With bit 17 set, bit 16 selects the launch edge of `pclkOut`: 1 means rising and 0 means falling.
- R8: With polarity bit 18 set, VSYNC asserts and releases together with the start of an HSYNC pulse. With bit 18 clear, VSYNC changes where an HSYNC pulse ends.
- R9: All four words are sampled on the first clock after reset and then on the last pixel of each frame. A write in mid-frame takes effect from the next frame.
- R10: While `rstN` is low, the position outputs and `pixReq` are zero, and HSYNC, VSYNC and data-enable sit at their inactive levels as set by the live polarity word. The first pixel after reset is the first sync pixel of the first sync line.
- R11: `pixelX` and `lineY` give the position of the pixel that the outputs currently show. `pixelX` counts up by one from 0 to the end of the line and then wraps. `lineY` changes only when `pixelX` wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSize | input | 32 | Active width and height word |
| cfgHoriz | input | 32 | Horizontal sync and porch word |
| cfgVert | input | 32 | Vertical sync and porch word |
| cfgPol | input | 32 | Polarity, launch edge and alignment word |
| hsyncOut | output | 1 | Horizontal sync to panel |
| vsyncOut | output | 1 | Vertical sync to panel |
| deOut | output | 1 | Data-enable to panel |
| pclkOut | output | 1 | Forwarded pixel clock, optionally inverted |
| pixelX | output | CNT_W (16) | Horizontal position within the line |
| lineY | output | CNT_W (16) | Line position within the frame |
| pixReq | output | 1 | Pixel request, one clock ahead of data-enable |

## Verification
The bench builds the block with the default counter width of 16 bits. That width is ample for the register values used. The bench keeps every porch, sync and active field small, so one frame lasts a few hundred clocks. Many whole frames therefore fit into one run, covering every launch-edge combination, both alignment modes, full inversion, zero vertical porches and a mid-frame rewrite. Outputs are sampled a quarter and three quarters into each clock, so a sync launched on the falling edge is seen one half-cycle after a sync launched on the rising edge.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  localparam int CFG_W = 32;
  localparam int ACT_W = 14;
  localparam int PORCH_W = 12;
  localparam int SYNC_W = 8;

  localparam int PPL_LSB = 0;
  localparam int LPP_LSB = 16;
  localparam int BP_LSB = 20;
  localparam int FP_LSB = 8;
  localparam int SW_LSB = 0;

  localparam int POL_INV_VS = 12;
  localparam int POL_INV_HS = 13;
  localparam int POL_INV_PCLK = 14;
  localparam int POL_INV_DE = 15;
  localparam int POL_EDGE_SEL = 16;
  localparam int POL_EDGE_EN = 17;
  localparam int POL_ALIGN = 18;

  typedef struct packed {
    logic hsRaw;
    logic vsRaw;
    logic deRaw;
    logic reqRaw;
    logic syncOnFall;
    logic invHs;
    logic invVs;
    logic invDe;
    logic invPclk;
  } lcdtg_strobe_t;
endpackage

// File: rtl/lcdtg_ctrl.sv
module lcdtg_ctrl
  import lcdtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  sizeWord,
  input  logic [CFG_W-1:0]  horizWord,
  input  logic [CFG_W-1:0]  vertWord,
  input  logic [CFG_W-1:0]  polWord,
  output lcdtg_strobe_t     stb,
  output logic [CNT_W-1:0]  hPos,
  output logic [CNT_W-1:0]  vPos
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic cfgValid;
  logic [CFG_W-1:0] sizeSh, horizSh, vertSh, polSh;
  logic [CFG_W-1:0] sizeEff, horizEff, vertEff, polEff;

  assign sizeEff  = cfgValid ? sizeSh  : sizeWord;
  assign horizEff = cfgValid ? horizSh : horizWord;
  assign vertEff  = cfgValid ? vertSh  : vertWord;
  assign polEff   = cfgValid ? polSh   : polWord;

  logic unusedCfgBits;
  assign unusedCfgBits = ^{sizeEff[CFG_W-1:LPP_LSB+ACT_W], sizeEff[LPP_LSB-1:PPL_LSB+ACT_W],
                           polEff[CFG_W-1:POL_ALIGN+1], polEff[POL_INV_VS-1:0]};

  // region boundaries for the frame in progress
  logic [CNT_W-1:0] hSyncEnd, hActBeg, hActEnd, hLast;
  logic [CNT_W-1:0] vSyncEnd, vActBeg, vActEnd, vLast;

  always_comb begin
    hSyncEnd = CNT_W'(horizEff[SW_LSB +: SYNC_W]) + ONE;
    hActBeg  = hSyncEnd + CNT_W'(horizEff[BP_LSB +: PORCH_W]) + ONE;
    hActEnd  = hActBeg + CNT_W'(sizeEff[PPL_LSB +: ACT_W]) + ONE;
    hLast    = hActEnd + CNT_W'(horizEff[FP_LSB +: PORCH_W]);
    vSyncEnd = CNT_W'(vertEff[SW_LSB +: SYNC_W]) + ONE;
    vActBeg  = vSyncEnd + CNT_W'(vertEff[BP_LSB +: PORCH_W]);
    vActEnd  = vActBeg + CNT_W'(sizeEff[LPP_LSB +: ACT_W]) + ONE;
    vLast    = vActEnd + CNT_W'(vertEff[FP_LSB +: PORCH_W]) - ONE;
  end

  function automatic logic inWin(input logic [CNT_W-1:0] p, input logic [CNT_W-1:0] lo,
                                 input logic [CNT_W-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  logic lineEnd, frameEnd;
  logic [CNT_W-1:0] hNext, vNext;

  always_comb begin
    lineEnd  = (hPos == hLast);
    frameEnd = lineEnd && (vPos == vLast);
    hNext    = lineEnd ? '0 : hPos + ONE;
    if (!lineEnd)      vNext = vPos;
    else if (frameEnd) vNext = '0;
    else               vNext = vPos + ONE;
  end

  logic vsAligned, vsShifted;
  always_comb begin
    vsAligned = (vPos < vSyncEnd);
    vsShifted = (vsAligned && !((vPos == '0) && (hPos < hSyncEnd))) ||
                ((vPos == vSyncEnd) && (hPos < hSyncEnd));
  end

  always_comb begin
    stb.hsRaw   = (hPos < hSyncEnd);
    stb.vsRaw   = polEff[POL_ALIGN] ? vsAligned : vsShifted;
    stb.deRaw   = inWin(hPos, hActBeg, hActEnd) && inWin(vPos, vActBeg, vActEnd);
    stb.reqRaw  = inWin(hNext, hActBeg, hActEnd) && inWin(vNext, vActBeg, vActEnd);
    stb.syncOnFall = polEff[POL_EDGE_EN] ?
                     (polEff[POL_EDGE_SEL] ? polEff[POL_INV_PCLK] : !polEff[POL_INV_PCLK]) : 1'b1;
    stb.invHs   = polEff[POL_INV_HS];
    stb.invVs   = polEff[POL_INV_VS];
    stb.invDe   = polEff[POL_INV_DE];
    stb.invPclk = polEff[POL_INV_PCLK];
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cfgValid <= 1'b0;
      sizeSh   <= '0;
      horizSh  <= '0;
      vertSh   <= '0;
      polSh    <= '0;
      hPos     <= '0;
      vPos     <= '0;
    end else begin
      if (!cfgValid || frameEnd) begin
        sizeSh  <= sizeWord;
        horizSh <= horizWord;
        vertSh  <= vertWord;
        polSh   <= polWord;
      end
      cfgValid <= 1'b1;
      hPos     <= hNext;
      vPos     <= vNext;
    end
  end
endmodule

// File: rtl/lcdtg_datapath.sv
module lcdtg_datapath
  import lcdtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  lcdtg_strobe_t    stb,
  input  logic [CNT_W-1:0] hPos,
  input  logic [CNT_W-1:0] vPos,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic             pclkOut,
  output logic [CNT_W-1:0] pixelX,
  output logic [CNT_W-1:0] lineY,
  output logic             pixReq
);
  localparam int N_SYNC = 2;

  logic deQ;
  logic [N_SYNC-1:0] syncQ, syncOut, syncRaw, syncInv;

  assign syncRaw = {stb.vsRaw, stb.hsRaw};
  assign syncInv = {stb.invVs, stb.invHs};

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      deQ    <= 1'b0;
      pixReq <= 1'b0;
      pixelX <= '0;
      lineY  <= '0;
      syncQ  <= '0;
    end else begin
      deQ    <= stb.deRaw;
      pixReq <= stb.reqRaw;
      pixelX <= hPos;
      lineY  <= vPos;
      syncQ  <= syncRaw;
    end
  end

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    logic lateQ;
    always_ff @(negedge clkIn or negedge rstN) begin
      if (!rstN) lateQ <= 1'b0;
      else       lateQ <= syncQ[i];
    end
    assign syncOut[i] = (stb.syncOnFall ? lateQ : syncQ[i]) ^ syncInv[i];
  end

  assign hsyncOut = syncOut[0];
  assign vsyncOut = syncOut[1];
  assign deOut    = deQ ^ stb.invDe;
  assign pclkOut  = clkIn ^ stb.invPclk;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [31:0]      cfgSize,
  input  logic [31:0]      cfgHoriz,
  input  logic [31:0]      cfgVert,
  input  logic [31:0]      cfgPol,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             deOut,
  output logic             pclkOut,
  output logic [CNT_W-1:0] pixelX,
  output logic [CNT_W-1:0] lineY,
  output logic             pixReq
);
  lcdtg_strobe_t stb;
  logic [CNT_W-1:0] hPos, vPos;

  lcdtg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clkIn(clkIn), .rstN(rstN),
    .sizeWord(cfgSize), .horizWord(cfgHoriz), .vertWord(cfgVert), .polWord(cfgPol),
    .stb(stb), .hPos(hPos), .vPos(vPos)
  );

  lcdtg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clkIn(clkIn), .rstN(rstN), .stb(stb), .hPos(hPos), .vPos(vPos),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pclkOut(pclkOut),
    .pixelX(pixelX), .lineY(lineY), .pixReq(pixReq)
  );
endmodule

// File: rtl/lcdtg_checker.sv
module lcdtg_checker #(
  parameter int CNT_W = 16
) (
  input logic             clkIn,
  input logic             rstN,
  input logic             hsyncOut,
  input logic             vsyncOut,
  input logic             deOut,
  input logic             pixReq,
  input logic             invHs,
  input logic             invVs,
  input logic             invDe,
  input logic [CNT_W-1:0] pixelX,
  input logic [CNT_W-1:0] lineY
);
  logic deAct, hsAct, vsAct;
  assign deAct = deOut ^ invDe;
  assign hsAct = hsyncOut ^ invHs;
  assign vsAct = vsyncOut ^ invVs;

  a_r4_req_leads_de: assert property (@(posedge clkIn) disable iff (!rstN)
    rstN |=> (deAct == $past(pixReq)));

  a_r3_de_excludes_hsync: assert property (@(posedge clkIn) disable iff (!rstN)
    deAct |-> !hsAct);

  a_r3_de_excludes_vsync: assert property (@(posedge clkIn) disable iff (!rstN)
    deAct |-> !vsAct);

  a_r11_pixel_steps: assert property (@(posedge clkIn) disable iff (!rstN)
    (pixelX != '0) |-> (pixelX == $past(pixelX) + CNT_W'(1)));

  a_r11_line_holds: assert property (@(posedge clkIn) disable iff (!rstN)
    (pixelX != '0) |-> $stable(lineY));
endmodule

bind lcd_timing_gen lcdtg_checker #(.CNT_W(CNT_W)) u_chk (
  .clkIn(clkIn), .rstN(rstN), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
  .deOut(deOut), .pixReq(pixReq), .invHs(stb.invHs), .invVs(stb.invVs),
  .invDe(stb.invDe), .pixelX(pixelX), .lineY(lineY)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgSize = '0, cfgHoriz = '0, cfgVert = '0, cfgPol = '0;
  logic hsyncOut, vsyncOut, deOut, pclkOut, pixReq;
  logic [CNT_W-1:0] pixelX, lineY;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timing_gen #(.CNT_W(CNT_W)) dut (
    .clkIn(clk), .rstN(rstN), .cfgSize(cfgSize), .cfgHoriz(cfgHoriz),
    .cfgVert(cfgVert), .cfgPol(cfgPol), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .pclkOut(pclkOut), .pixelX(pixelX), .lineY(lineY), .pixReq(pixReq)
  );

  task automatic chk(input string tag, input string focus, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s (case %s) t=%0t actual=%0d expected=%0d", tag, focus, $time, act, exp);
    end
  endtask

  function automatic int fld(input logic [31:0] w, input int lsb, input int width);
    return int'((w >> lsb) & ((32'd1 << width) - 32'd1));
  endfunction

  function automatic int lineLen(input logic [31:0] sz, input logic [31:0] hz);
    return (fld(hz, 0, 8) + 1) + (fld(hz, 20, 12) + 1) + (fld(sz, 0, 14) + 1) + (fld(hz, 8, 12) + 1);
  endfunction

  function automatic int frameLen(input logic [31:0] sz, input logic [31:0] vt);
    return (fld(vt, 0, 8) + 1) + fld(vt, 20, 12) + (fld(sz, 16, 14) + 1) + fld(vt, 8, 12);
  endfunction

  // returns {hsync, vsync, de} as active-high levels
  function automatic logic [2:0] expRaw(input int h, input int v, input logic [31:0] sz,
                                        input logic [31:0] hz, input logic [31:0] vt,
                                        input logic [31:0] pl);
    int hsL = fld(hz, 0, 8) + 1;
    int aH0 = hsL + fld(hz, 20, 12) + 1;
    int aH1 = aH0 + fld(sz, 0, 14) + 1;
    int vsL = fld(vt, 0, 8) + 1;
    int aV0 = vsL + fld(vt, 20, 12);
    int aV1 = aV0 + fld(sz, 16, 14) + 1;
    int hT = lineLen(sz, hz);
    int lin = v * hT + h;
    logic hs, vs, de;
    hs = (h < hsL);
    if (pl[18]) vs = (v < vsL);
    else        vs = (lin >= hsL) && (lin < vsL * hT + hsL);
    de = (h >= aH0) && (h < aH1) && (v >= aV0) && (v < aV1);
    return {hs, vs, de};
  endfunction

  task automatic runCase(input string focus, input logic [31:0] s, input logic [31:0] h,
                         input logic [31:0] v, input logic [31:0] p, input int frames,
                         input int changeAt, input logic [31:0] s2, input logic [31:0] h2,
                         input logic [31:0] v2);
    int mh, mv, hT, vT, nh, nv, ncycles;
    bit mFirst, frameEnd, fall;
    logic prevHs, prevVs;
    logic [2:0] raw, nraw;
    logic [31:0] sS, hS, vS, pS, sU, hU, vU, pU;
    rstN = 1'b0;
    cfgSize = s; cfgHoriz = h; cfgVert = v; cfgPol = p;
    mh = 0; mv = 0; mFirst = 1; prevHs = 0; prevVs = 0;
    sS = '0; hS = '0; vS = '0; pS = '0;
    ncycles = frames * lineLen(s, h) * frameLen(s, v);
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R10: reset levels follow the live polarity word
    chk("R10 hsync idle", focus, int'(hsyncOut), int'(p[13]));
    chk("R10 vsync idle", focus, int'(vsyncOut), int'(p[12]));
    chk("R10 de idle", focus, int'(deOut), int'(p[15]));
    chk("R10 req idle", focus, int'(pixReq), 0);
    chk("R10 pos idle", focus, int'(pixelX) + int'(lineY), 0);
    #(CLK_PERIOD/2);
    rstN = 1'b1;
    for (int c = 0; c < ncycles; c++) begin
      @(posedge clk);
      sU = mFirst ? cfgSize : sS;
      hU = mFirst ? cfgHoriz : hS;
      vU = mFirst ? cfgVert : vS;
      pU = mFirst ? cfgPol : pS;
      hT = lineLen(sU, hU);
      vT = frameLen(sU, vU);
      raw = expRaw(mh, mv, sU, hU, vU, pU);
      nh = (mh == hT - 1) ? 0 : mh + 1;
      nv = (mh == hT - 1) ? ((mv == vT - 1) ? 0 : mv + 1) : mv;
      nraw = expRaw(nh, nv, sU, hU, vU, pU);
      frameEnd = (mh == hT - 1) && (mv == vT - 1);
      if (mFirst || frameEnd) begin  // R9: shadow load at frame boundary
        sS = cfgSize; hS = cfgHoriz; vS = cfgVert; pS = cfgPol;
      end
      mFirst = 0;
      fall = pS[17] ? (pS[16] ? pS[14] : !pS[14]) : 1'b1;
      #(CLK_PERIOD/4);
      // R7: falling-edge launched syncs still show the previous value here
      chk("R7 hsync early", focus, int'(hsyncOut), int'((fall ? prevHs : raw[2]) ^ pS[13]));
      chk("R7 vsync early", focus, int'(vsyncOut), int'((fall ? prevVs : raw[1]) ^ pS[12]));
      chk("R6 pclk high phase", focus, int'(pclkOut), int'(!pS[14]));
      if (c == changeAt) begin
        cfgSize = s2; cfgHoriz = h2; cfgVert = v2;
      end
      #(CLK_PERIOD/2);
      chk("R1 hsync", focus, int'(hsyncOut), int'(raw[2] ^ pS[13]));
      chk("R2 vsync", focus, int'(vsyncOut), int'(raw[1] ^ pS[12]));
      chk("R3 de", focus, int'(deOut), int'(raw[0] ^ pS[15]));
      chk("R4 pixReq", focus, int'(pixReq), int'(nraw[0]));
      chk("R11 pixelX", focus, int'(pixelX), mh);
      chk("R11 lineY", focus, int'(lineY), mv);
      chk("R6 pclk low phase", focus, int'(pclkOut), int'(pS[14]));
      prevHs = raw[2];
      prevVs = raw[1];
      mh = nh;
      mv = nv;
    end
  endtask

  function automatic logic [31:0] mkSize(input int ppl, input int lpp);
    return (32'(lpp) << 16) | 32'(ppl);
  endfunction

  function automatic logic [31:0] mkTime(input int bp, input int fp, input int sw);
    return (32'(bp) << 20) | (32'(fp) << 8) | 32'(sw);
  endfunction

  initial begin
    int seedInit;
    logic [31:0] rs, rh, rv, rp;
    seedInit = $urandom(32'd4711);
    // R1: baseline, all active high, syncs on the opposite edge
    runCase("R1", mkSize(7, 3), mkTime(2, 1, 1), mkTime(2, 1, 1), 32'h0, 2, -1, 0, 0, 0);
    // R2: both vertical porches zero, with full inversion, rising launch and alignment
    runCase("R2", mkSize(5, 2), mkTime(1, 2, 0), mkTime(0, 0, 2), 32'h0007_F000, 2, -1, 0, 0, 0);
    // R5: inverted sync and enable only
    runCase("R5", mkSize(4, 2), mkTime(0, 0, 2), mkTime(1, 1, 0), 32'h0000_B000, 2, -1, 0, 0, 0);
    // R7: explicit falling launch, then explicit rising launch
    runCase("R7", mkSize(6, 2), mkTime(1, 1, 1), mkTime(1, 2, 1), 32'h0002_0000, 2, -1, 0, 0, 0);
    runCase("R7", mkSize(6, 2), mkTime(1, 1, 1), mkTime(1, 2, 1), 32'h0003_0000, 2, -1, 0, 0, 0);
    // R6: inverted output clock with default launch
    runCase("R6", mkSize(3, 3), mkTime(0, 1, 0), mkTime(1, 0, 0), 32'h0000_4000, 2, -1, 0, 0, 0);
    // R8: aligned vertical sync
    runCase("R8", mkSize(5, 1), mkTime(1, 1, 2), mkTime(1, 1, 2), 32'h0004_0000, 2, -1, 0, 0, 0);
    // R9: rewrite timing mid-frame, must apply from the next frame
    runCase("R9", mkSize(6, 2), mkTime(1, 1, 1), mkTime(1, 1, 0), 32'h0, 3, 20,
            mkSize(9, 4), mkTime(3, 2, 0), mkTime(0, 2, 1));
    for (int k = 0; k < 5; k++) begin
      rs = mkSize(int'($urandom_range(12, 0)), int'($urandom_range(6, 0)));
      rh = mkTime(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
      rv = mkTime(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), int'($urandom_range(2, 0)));
      rp = ($urandom() & 32'h0007_F000);
      runCase("R1", rs, rh, rv, rp, 2, -1, 0, 0, 0);
    end
    if (seedInit == 0) checks = checks + 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule